// File: doc/BRIEF.md
# Phase-Shift Tap Selection Unit

This unit converts a requested fractional phase offset into a whole number of delay-line taps. The request is a signed phase code in 256ths of the input clock period. The unit also takes the clock period and the present tap delay, both in picoseconds. The time offset it aims for is code × period / 256. It returns the signed tap count whose total delay lands nearest that target. Because the tap delay drifts with process, voltage and temperature, the count is recomputed from the live tap delay input and not from a fixed nominal figure.

The unit has two modes. In fixed mode a start request loads a constant code. In variable mode single-cycle increment and decrement pulses walk the code up or down by one count. Each accepted request runs a bit-serial restoring divide. The `done_o` pulse marks the cycle in which the new tap count is valid. If the tap delay input changes while the unit is idle, a recalculation starts by itself.

When period/256 is shorter than one tap, the effective resolution is one tap. A one-count step of the code can then leave the tap count unchanged.

Top module: `phase_tap_sel`

## Requirements
- R1: While `rst_ni` is low, `code_o` is 0, `tap_cnt_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: The result is round(|code| × period / (256 × tap)) with the sign of the code, where a remainder of exactly one half rounds away from zero.
- R3: The magnitude of `tap_cnt_o` never exceeds MAX_TAPS; larger results saturate at ±MAX_TAPS, and a tap delay of 0 gives the saturated value.
- R4: In fixed mode (`mode_var_i`=0), a start request loads `fixed_code_i` into the code, with −256 clamped to −255. Increment and decrement pulses have no effect in fixed mode.
- R5: In variable mode (`mode_var_i`=1), an increment adds one and a decrement subtracts one, saturating at +255 and −255. Each accepted step starts a calculation. Increment and decrement together do nothing. Start recomputes the current code without loading `fixed_code_i`.
- R6: An accepted request raises `busy_o` for exactly PER_W+9 cycles. Requests that arrive while busy are ignored and leave the code unchanged.
- R7: When idle, a `tap_ps_i` value that differs from the one used by the last calculation starts a recalculation. A change that arrives while busy is picked up once the unit is idle.
- R8: When period/256 is shorter than the tap delay, a one-count step of the code leaves `tap_cnt_o` unchanged if the same tap count is still nearest.
- R9: `done_o` is a single-cycle pulse in the first cycle after `busy_o` falls, and `tap_cnt_o` changes only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_var_i | input | 1 | 0 = fixed code, 1 = variable stepping |
| fixed_code_i | input | 9 | Signed phase code loaded on start in fixed mode |
| start_i | input | 1 | Request a calculation |
| inc_i | input | 1 | Variable mode: step code up by one |
| dec_i | input | 1 | Variable mode: step code down by one |
| period_ps_i | input | PER_W | Input clock period in ps |
| tap_ps_i | input | TAP_W | Present tap delay in ps |
| code_o | output | 9 | Current signed phase code |
| tap_cnt_o | output | CNT_W | Signed selected tap count |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse: new tap count valid |

## Verification
The bench builds the unit with PER_W=16, TAP_W=8 and CNT_W=10, which gives periods up to about 65 ns. MAX_TAPS is lowered to 200 so that long periods combined with short taps reach saturation in both signs. Under these values the bench also reaches exact half-tap remainders and a zero tap delay. It covers the sub-tap region near 150 MHz, where a one-count code step leaves the tap count unchanged. The 24-bit dividend gives a 25-cycle busy window. The bench aims tap changes and extra requests into that window.

// File: rtl/phase_tap_pkg.sv
package phase_tap_pkg;
  localparam int CODE_W   = 9;
  localparam int CODE_LIM = 255;

  typedef logic signed [CODE_W-1:0] code_t;
  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_FIN} div_st_e;

  function automatic code_t clamp_code(input code_t c);
    if (c < -CODE_LIM) return code_t'(-CODE_LIM);
    return c;
  endfunction
endpackage

// File: rtl/phase_code_ctl.sv
module phase_code_ctl
  import phase_tap_pkg::*;
#(
  parameter int TAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             mode_var_i,
  input  logic             start_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  code_t            fixed_code_i,
  input  logic [TAP_W-1:0] tap_ps_i,
  output logic             go_o,
  output code_t            code_o,
  output code_t            code_nx_o
);
  logic [TAP_W-1:0] tap_last_q;
  logic             step, tap_chg;

  assign step    = mode_var_i & (inc_i ^ dec_i);
  assign tap_chg = tap_ps_i != tap_last_q;
  assign go_o    = !busy_i & (start_i | step | tap_chg);

  always_comb begin
    code_nx_o = code_o;
    if (step) begin
      if (inc_i && code_o != code_t'(CODE_LIM))       code_nx_o = code_o + code_t'(1);
      else if (dec_i && code_o != code_t'(-CODE_LIM)) code_nx_o = code_o - code_t'(1);
    end else if (start_i && !mode_var_i) begin
      code_nx_o = clamp_code(fixed_code_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o     <= '0;
      tap_last_q <= '0;
    end else if (go_o) begin
      code_o     <= code_nx_o;
      tap_last_q <= tap_ps_i;
    end
  end

  a_r5_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o <= code_t'(CODE_LIM) && code_o >= code_t'(-CODE_LIM));
  a_r6_code_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(code_o));
  a_r5_inc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && mode_var_i && inc_i && !dec_i && code_o != code_t'(CODE_LIM))
      |=> code_o == $past(code_o) + code_t'(1));
  a_r4_fixed_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_var_i && !start_i) |=> $stable(code_o));
endmodule

// File: rtl/tap_divider.sv
module tap_divider
  import phase_tap_pkg::*;
#(
  parameter int PER_W    = 16,
  parameter int TAP_W    = 8,
  parameter int CNT_W    = 10,
  parameter int MAX_TAPS = 400
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    go_i,
  input  code_t                   code_i,
  input  logic [PER_W-1:0]        period_i,
  input  logic [TAP_W-1:0]        tap_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [CNT_W-1:0] tap_cnt_o
);
  localparam int NUM_W = PER_W + 8;
  localparam int DEN_W = TAP_W + 8;
  localparam int CYC_W = $clog2(NUM_W);

  div_st_e          st_q;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CYC_W-1:0] cyc_q;
  logic             neg_q;

  logic [7:0]              mag;
  logic [DEN_W:0]          trial;
  logic                    fits, round_up;
  logic [NUM_W:0]          q_rnd, q_sat;
  logic signed [CNT_W-1:0] mag_cnt, result;

  assign mag      = code_i[CODE_W-1] ? 8'(-code_i) : code_i[7:0];
  assign trial    = {rem_q, quo_q[NUM_W-1]};
  assign fits     = trial >= {1'b0, den_q};
  // nearest tap: bump when twice the remainder reaches the divisor
  assign round_up = {rem_q, 1'b0} >= {1'b0, den_q};
  assign q_rnd    = {1'b0, quo_q} + (NUM_W+1)'(round_up);
  assign q_sat    = (q_rnd > (NUM_W+1)'(MAX_TAPS)) ? (NUM_W+1)'(MAX_TAPS) : q_rnd;
  assign mag_cnt  = $signed(CNT_W'(q_sat));
  assign result   = neg_q ? -mag_cnt : mag_cnt;
  assign busy_o   = st_q != ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      quo_q     <= '0;
      rem_q     <= '0;
      den_q     <= '0;
      cyc_q     <= '0;
      neg_q     <= 1'b0;
      done_o    <= 1'b0;
      tap_cnt_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (go_i) begin
          quo_q <= NUM_W'(mag) * NUM_W'(period_i);
          den_q <= {tap_i, 8'h00};
          rem_q <= '0;
          neg_q <= code_i[CODE_W-1];
          cyc_q <= '0;
          st_q  <= ST_DIV;
        end
        ST_DIV: begin
          rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
          quo_q <= {quo_q[NUM_W-2:0], fits};
          cyc_q <= cyc_q + CYC_W'(1);
          if (cyc_q == CYC_W'(NUM_W-1)) st_q <= ST_FIN;
        end
        ST_FIN: begin
          tap_cnt_o <= result;
          done_o    <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_tap_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_cnt_o <= MAX_TAPS && tap_cnt_o >= -MAX_TAPS);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_tap_only_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(tap_cnt_o));
  a_r2_sign_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIN && !neg_q) |=> tap_cnt_o >= 0);
  a_r6_go_ignored_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DIV && cyc_q != CYC_W'(NUM_W-1)) |=> st_q == ST_DIV);
endmodule

// File: rtl/phase_tap_sel.sv
module phase_tap_sel
  import phase_tap_pkg::*;
#(
  parameter int PER_W    = 16,
  parameter int TAP_W    = 8,
  parameter int CNT_W    = 10,
  parameter int MAX_TAPS = 400
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mode_var_i,
  input  logic signed [8:0]       fixed_code_i,
  input  logic                    start_i,
  input  logic                    inc_i,
  input  logic                    dec_i,
  input  logic [PER_W-1:0]        period_ps_i,
  input  logic [TAP_W-1:0]        tap_ps_i,
  output logic signed [8:0]       code_o,
  output logic signed [CNT_W-1:0] tap_cnt_o,
  output logic                    busy_o,
  output logic                    done_o
);
  logic  go;
  code_t code_nx;

  phase_code_ctl #(.TAP_W(TAP_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_o),
    .mode_var_i  (mode_var_i),
    .start_i     (start_i),
    .inc_i       (inc_i),
    .dec_i       (dec_i),
    .fixed_code_i(fixed_code_i),
    .tap_ps_i    (tap_ps_i),
    .go_o        (go),
    .code_o      (code_o),
    .code_nx_o   (code_nx)
  );

  tap_divider #(
    .PER_W(PER_W), .TAP_W(TAP_W), .CNT_W(CNT_W), .MAX_TAPS(MAX_TAPS)
  ) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .code_i   (code_nx),
    .period_i (period_ps_i),
    .tap_i    (tap_ps_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .tap_cnt_o(tap_cnt_o)
  );
endmodule

// File: tb/phase_tap_sel_tb.sv
module phase_tap_sel_tb;
  localparam int PER_W = 16, TAP_W = 8, CNT_W = 10, MAX = 200;
  localparam int NUM_W = PER_W + 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_var = 1'b0, start = 1'b0, inc = 1'b0, dec = 1'b0;
  logic signed [8:0] fixed_code = '0;
  logic [PER_W-1:0] period = 16'd6667;
  logic [TAP_W-1:0] tap = 8'd45;
  logic signed [8:0] code_o;
  logic signed [CNT_W-1:0] tap_cnt_o;
  logic busy_o, done_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  phase_tap_sel #(.PER_W(PER_W), .TAP_W(TAP_W), .CNT_W(CNT_W), .MAX_TAPS(MAX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_var_i(mode_var), .fixed_code_i(fixed_code),
    .start_i(start), .inc_i(inc), .dec_i(dec), .period_ps_i(period), .tap_ps_i(tap),
    .code_o(code_o), .tap_cnt_o(tap_cnt_o), .busy_o(busy_o), .done_o(done_o));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp_v);
    end
  endtask

  function automatic int exp_taps(int c, int p, int t);
    longint num, den, q, r;
    num = longint'(c < 0 ? -c : c) * longint'(p);
    den = 256 * longint'(t);
    if (den == 0) q = MAX;
    else begin
      q = num / den; r = num % den;
      if (2 * r >= den) q++;
    end
    if (q > MAX) q = MAX;
    return c < 0 ? -int'(q) : int'(q);
  endfunction

  // reference model
  int m_code, m_last, cd, m_pend, m_tap;
  bit m_done;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_last = 0; cd = 0; m_tap = 0; m_done = 0; m_pend = 0;
    end else begin
      bit step;
      m_done = 0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin m_tap = m_pend; m_done = 1; end
      end else begin
        step = mode_var && (inc != dec);
        if (start || step || int'(tap) != m_last) begin
          if (step) m_code = inc ? (m_code < 255 ? m_code + 1 : 255)
                                 : (m_code > -255 ? m_code - 1 : -255);
          else if (start && !mode_var) m_code = (int'(fixed_code) < -255) ? -255 : int'(fixed_code);
          m_pend = exp_taps(m_code, int'(period), int'(tap));
          m_last = int'(tap);
          cd = NUM_W + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(int'(code_o) == m_code, "R5", "code", int'(code_o), m_code);
      chk(busy_o == (cd > 0), "R6", "busy", int'(busy_o), int'(cd > 0));
      chk(done_o == m_done, "R9", "done", int'(done_o), int'(m_done));
      chk(int'(tap_cnt_o) == m_tap, "R9", "tap_cnt", int'(tap_cnt_o), m_tap);
    end
  end

  task automatic wait_done();
    int n = 0;
    do begin @(negedge clk); n++; end while (!done_o && n < 200);
    chk(done_o, "R6", "done_seen", int'(done_o), 1);
  endtask

  task automatic do_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask
  task automatic do_inc();
    inc = 1'b1; @(negedge clk); inc = 1'b0;
  endtask
  task automatic do_dec();
    dec = 1'b1; @(negedge clk); dec = 1'b0;
  endtask
  task automatic run_fixed(input int c);
    fixed_code = 9'(c); do_start(); wait_done();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(code_o == 0 && tap_cnt_o == 0 && !busy_o && !done_o, "R1", "reset",
        int'(tap_cnt_o), 0);
    rst_n = 1'b1;
    wait_done();  // tap differs from cleared record: auto run
    chk(tap_cnt_o == 0, "R1", "code0_taps", int'(tap_cnt_o), 0);

    // R2 nearest tap
    run_fixed(26);   chk(tap_cnt_o == 15,  "R2", "c26",  int'(tap_cnt_o), 15);
    run_fixed(-26);  chk(tap_cnt_o == -15, "R2", "cm26", int'(tap_cnt_o), -15);

    // R7 idle tap change recomputes
    period = 16'd200; @(negedge clk);
    tap = 8'd40; wait_done();
    chk(tap_cnt_o == -1, "R7", "auto", int'(tap_cnt_o), -1);

    // R2 half rounding
    run_fixed(128);  chk(tap_cnt_o == 3,  "R2", "half",    int'(tap_cnt_o), 3);
    run_fixed(-128); chk(tap_cnt_o == -3, "R2", "neghalf", int'(tap_cnt_o), -3);
    run_fixed(127);  chk(tap_cnt_o == 2,  "R2", "below",   int'(tap_cnt_o), 2);

    // R4 clamp and ignored steps
    run_fixed(-256);
    chk(code_o == -255, "R4", "clamp", int'(code_o), -255);
    chk(tap_cnt_o == -5, "R4", "clamp_taps", int'(tap_cnt_o), -5);
    do_inc(); do_dec();
    chk(code_o == -255 && !busy_o, "R4", "fixed_step", int'(code_o), -255);

    // R3 saturation
    period = 16'd60000;
    run_fixed(255);  chk(tap_cnt_o == MAX,  "R3", "sat_pos", int'(tap_cnt_o), MAX);
    run_fixed(-255); chk(tap_cnt_o == -MAX, "R3", "sat_neg", int'(tap_cnt_o), -MAX);
    tap = 8'd0; wait_done();
    chk(tap_cnt_o == -MAX, "R3", "tap0", int'(tap_cnt_o), -MAX);

    // R8 sub-tap resolution
    tap = 8'd45; period = 16'd6670; wait_done();
    run_fixed(3); chk(tap_cnt_o == 2, "R8", "c3", int'(tap_cnt_o), 2);
    mode_var = 1'b1;
    do_inc(); wait_done();
    chk(code_o == 4, "R5", "inc", int'(code_o), 4);
    chk(tap_cnt_o == 2, "R8", "c4_same", int'(tap_cnt_o), 2);

    // R5 both pulses, saturation, start in variable mode
    inc = 1'b1; dec = 1'b1; @(negedge clk); inc = 1'b0; dec = 1'b0;
    @(negedge clk);
    chk(code_o == 4 && !busy_o, "R5", "both", int'(code_o), 4);
    fixed_code = 9'sd100; do_start(); wait_done();
    chk(code_o == 4, "R5", "var_start", int'(code_o), 4);
    mode_var = 1'b0; run_fixed(255); mode_var = 1'b1;
    do_inc(); wait_done();
    chk(code_o == 255, "R5", "sat", int'(code_o), 255);
    do_dec(); wait_done();
    chk(code_o == 254, "R5", "dec", int'(code_o), 254);

    // R6 busy length and ignored requests
    begin
      int n = 0;
      start = 1'b1; @(negedge clk); start = 1'b0;
      inc = 1'b1; @(negedge clk); inc = 1'b0; n = 2;
      while (busy_o && n < 200) begin @(negedge clk); n++; end
      chk(n - 1 == NUM_W + 1, "R6", "busy_len", n - 1, NUM_W + 1);
      chk(code_o == 254, "R6", "ignored", int'(code_o), 254);
    end

    // R7 tap change during busy picked up afterwards
    start = 1'b1; @(negedge clk); start = 1'b0;
    tap = 8'd50;
    wait_done();
    @(negedge clk);
    chk(busy_o, "R7", "rerun", int'(busy_o), 1);
    wait_done();
    chk(tap_cnt_o == 132, "R7", "rerun_val", int'(tap_cnt_o), 132);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule